// File: doc/BRIEF.md
# Pre-Adder Multiply-Add Arithmetic Slice

This block is a pipelined arithmetic slice. It first forms the sum or the difference of a 25-bit operand D and the low 25 bits of a 30-bit operand A. It multiplies that result by an 18-bit operand B. The signed product then enters a post-adder through three operand selectors, X, Y and Z, which are steered by a 7-bit operation code. A 48-bit operand C and the slice's own registered output can also be routed into the post-adder. The post-adder adds its operands together with a carry, or subtracts them from Z. The 48-bit result is registered and driven out.

Every pipeline register has its own clock enable and its own synchronous reset. These are the operand registers (A, two B stages, C and D), the pre-adder result register, the product register, the output register, the input-mode register and the control register. With all of them enabled, a change on A, B or D reaches the output four clock edges later. The product reaches the output only when the operation code routes it into the post-adder. The slice therefore serves as a plain multiplier, a multiply-accumulator, or a multiply-add with C, depending on the code applied.

Top module: `preadd_mac_slice`

## Requirements
- R1: Each register clears to zero on the clock edge at which its reset input is high, and the reset takes effect even when the register's clock enable is low. The output reads 0 after reset.
- R2: Mode bit inMode[3] sets the pre-adder direction: 1 gives D − A and 0 gives D + A. Only A[24:0] takes part, and the result wraps to 25-bit two's complement. A[29:25] have no effect on the product.
- R3: The 25-bit pre-adder result and the 18-bit B are multiplied as signed numbers. The 43-bit product is sign-extended to 48 bits, so a negative product appears on pOut in 48-bit two's complement.
- R4: With every clock enable high and inMode[4] = 0, a change on aIn, bIn or dIn appears on pOut after the fourth rising edge and not before.
- R5: Mode bit inMode[4] = 1 feeds the multiplier from the first B stage instead of the second. A change on bIn then appears on pOut after the third edge.
- R6: Field opMode[6:4] selects Z: 000 gives zero, 010 gives the registered output (accumulate) and 011 gives the C register. Every other code gives zero.
- R7: The product enters the post-adder only when opMode[3:0] = 0101. If only opMode[1:0] = 01 or only opMode[3:2] = 01, the product contributes nothing.
- R8: Field opMode[1:0] = 10 gives the registered output on X, and 11 gives the concatenation {A register, second B stage} on X. Field opMode[3:2] = 10 gives all ones on Y, and 11 gives the C register on Y.
- R9: With opMode = 0000000 and carry 0, pOut becomes 0 whatever the values of A, B and D.
- R10: aluMode = 0000 gives P = Z + X + Y + carry, and aluMode = 0011 gives P = Z − (X + Y + carry). Every other aluMode code behaves as 0000.
- R11: opMode, aluMode and carryIn are registered under ceCtrl. A change on them reaches pOut at the second edge after it is applied, and the first edge still uses the previous codes.
- R12: A register whose clock enable is low keeps its value. With ceP low, pOut holds. With ceM low, a change of B does not reach pOut until ceM is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| aIn | input | 30 | Operand A; low 25 bits feed the pre-adder |
| bIn | input | 18 | Operand B, multiplier input |
| cIn | input | 48 | Operand C for the post-adder |
| dIn | input | 25 | Operand D for the pre-adder |
| inMode | input | 5 | Bit 3 pre-adder subtract, bit 4 first-B-stage select |
| opMode | input | 7 | Operand selector codes: [6:4] Z, [3:2] Y, [1:0] X |
| aluMode | input | 4 | Post-adder function: 0000 add, 0011 subtract from Z |
| carryIn | input | 1 | Carry into the post-adder |
| ceA | input | 1 | Clock enable, A register |
| ceB1 | input | 1 | Clock enable, first B stage |
| ceB2 | input | 1 | Clock enable, second B stage |
| ceC | input | 1 | Clock enable, C register |
| ceD | input | 1 | Clock enable, D register |
| ceAd | input | 1 | Clock enable, pre-adder result register |
| ceM | input | 1 | Clock enable, product register |
| ceP | input | 1 | Clock enable, output register |
| ceInMode | input | 1 | Clock enable, input-mode register |
| ceCtrl | input | 1 | Clock enable, opMode/aluMode/carry register |
| rstA | input | 1 | Synchronous reset, A register |
| rstB | input | 1 | Synchronous reset, both B stages |
| rstC | input | 1 | Synchronous reset, C register |
| rstD | input | 1 | Synchronous reset, D register |
| rstAd | input | 1 | Synchronous reset, pre-adder result register |
| rstM | input | 1 | Synchronous reset, product register |
| rstP | input | 1 | Synchronous reset, output register |
| rstInMode | input | 1 | Synchronous reset, input-mode register |
| rstCtrl | input | 1 | Synchronous reset, control register |
| pOut | output | 48 | Registered post-adder result |

## Verification
Each result has a fixed due edge. Operand changes on A, D and the second B stage are due at the fourth rising edge. With the first B stage selected, a B change is due at the third edge. Changes on opMode, aluMode, carryIn and C are due at the second edge, and an output reset is due at the first. The bench drives every stimulus at a falling edge and counts rising edges explicitly. For latency cases it samples at the falling edge just before the due edge, where the old value must still be present, and again just after it, where the new value must have appeared. Steady-state cases wait well past the longest path before sampling.

// File: rtl/pam_pkg.sv
package pam_pkg;

  // X operand selection
  typedef enum logic [1:0] {
    XS_ZERO = 2'd0,
    XS_PROD = 2'd1,
    XS_P    = 2'd2,
    XS_AB   = 2'd3
  } xSelE;

  // Y operand selection
  typedef enum logic [1:0] {
    YS_ZERO = 2'd0,
    YS_PROD = 2'd1,
    YS_ONES = 2'd2,
    YS_C    = 2'd3
  } ySelE;

  // Z operand selection
  typedef enum logic [1:0] {
    ZS_ZERO = 2'd0,
    ZS_P    = 2'd1,
    ZS_C    = 2'd2
  } zSelE;

  // Strobes from control to datapath
  typedef struct packed {
    logic preSub;   // pre-adder subtracts A from D
    logic bFirst;   // multiplier takes the first B stage
    xSelE xSel;
    ySelE ySel;
    zSelE zSel;
    logic aluSub;   // post-adder computes Z - (X+Y+carry)
    logic carry;
  } ctrlStrbT;

endpackage

// File: rtl/pam_pipe_reg.sv
module pam_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end

  // R1: synchronous clear regardless of enable
  p_clear_r1: assert property (@(posedge clk) rst |=> (q == '0));

  // R12: disabled register holds its value
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));

endmodule

// File: rtl/pam_ctrl.sv
module pam_ctrl
  import pam_pkg::*;
(
  input  logic     clk,
  input  logic [4:0] inMode,
  input  logic [6:0] opMode,
  input  logic [3:0] aluMode,
  input  logic     carryIn,
  input  logic     ceInMode,
  input  logic     ceCtrl,
  input  logic     rstInMode,
  input  logic     rstCtrl,
  output ctrlStrbT strb
);

  localparam logic [3:0] ALU_SUB_CODE = 4'b0011;
  localparam logic [3:0] PROD_PAIR    = 4'b0101;

  logic [4:0] inModeReg;
  logic [6:0] opModeReg;
  logic [3:0] aluModeReg;
  logic       carryReg;
  logic       unusedInModeBits;

  always_ff @(posedge clk) begin
    if (rstInMode)     inModeReg <= '0;
    else if (ceInMode) inModeReg <= inMode;
  end

  always_ff @(posedge clk) begin
    if (rstCtrl) begin
      opModeReg  <= '0;
      aluModeReg <= '0;
      carryReg   <= 1'b0;
    end else if (ceCtrl) begin
      opModeReg  <= opMode;
      aluModeReg <= aluMode;
      carryReg   <= carryIn;
    end
  end

  assign unusedInModeBits = ^inModeReg[2:0];

  always_comb begin
    strb        = '0;
    strb.preSub = inModeReg[3];
    strb.bFirst = inModeReg[4];
    strb.carry  = carryReg;
    strb.aluSub = (aluModeReg == ALU_SUB_CODE);

    // product goes whole onto X when both X and Y ask for it
    unique case (opModeReg[1:0])
      2'b00:   strb.xSel = XS_ZERO;
      2'b01:   strb.xSel = (opModeReg[3:0] == PROD_PAIR) ? XS_PROD : XS_ZERO;
      2'b10:   strb.xSel = XS_P;
      default: strb.xSel = XS_AB;
    endcase

    unique case (opModeReg[3:2])
      2'b10:   strb.ySel = YS_ONES;
      2'b11:   strb.ySel = YS_C;
      default: strb.ySel = YS_ZERO;
    endcase

    unique case (opModeReg[6:4])
      3'b010:  strb.zSel = ZS_P;
      3'b011:  strb.zSel = ZS_C;
      default: strb.zSel = ZS_ZERO;
    endcase
  end

  // R11: control register clears on reset
  p_ctrl_clear_r11: assert property (@(posedge clk)
    rstCtrl |=> (opModeReg == '0 && aluModeReg == '0 && !carryReg));

  // R7: product selected only when the Y half asks for it too
  p_prod_pair_r7: assert property (@(posedge clk) disable iff (rstCtrl)
    (strb.xSel == XS_PROD) |-> (opModeReg[3:2] == 2'b01));

  // R7: Y never carries a product half on its own
  p_y_no_prod_r7: assert property (@(posedge clk) disable iff (rstCtrl)
    (opModeReg[3:2] == 2'b01) |-> (strb.ySel == YS_ZERO));

endmodule

// File: rtl/pam_datapath.sv
module pam_datapath
  import pam_pkg::*;
#(
  parameter int A_W = 30,
  parameter int B_W = 18,
  parameter int C_W = 48,
  parameter int D_W = 25,
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic [A_W-1:0] aIn,
  input  logic [B_W-1:0] bIn,
  input  logic [C_W-1:0] cIn,
  input  logic [D_W-1:0] dIn,
  input  logic           ceA,
  input  logic           ceB1,
  input  logic           ceB2,
  input  logic           ceC,
  input  logic           ceD,
  input  logic           ceAd,
  input  logic           ceM,
  input  logic           ceP,
  input  logic           rstA,
  input  logic           rstB,
  input  logic           rstC,
  input  logic           rstD,
  input  logic           rstAd,
  input  logic           rstM,
  input  logic           rstP,
  input  ctrlStrbT       strb,
  output logic [P_W-1:0] pOut
);

  localparam int PRE_W  = D_W;
  localparam int PROD_W = PRE_W + B_W;
  localparam int EXT_W  = P_W - PROD_W;

  logic [A_W-1:0] aReg;
  logic [B_W-1:0] b1Reg, b2Reg;
  logic [C_W-1:0] cReg;
  logic [D_W-1:0] dReg;

  // operand registers
  pam_pipe_reg #(.W(A_W)) aStage  (.clk(clk), .ce(ceA),  .rst(rstA), .d(aIn),   .q(aReg));
  pam_pipe_reg #(.W(B_W)) b1Stage (.clk(clk), .ce(ceB1), .rst(rstB), .d(bIn),   .q(b1Reg));
  pam_pipe_reg #(.W(B_W)) b2Stage (.clk(clk), .ce(ceB2), .rst(rstB), .d(b1Reg), .q(b2Reg));
  pam_pipe_reg #(.W(C_W)) cStage  (.clk(clk), .ce(ceC),  .rst(rstC), .d(cIn),   .q(cReg));
  pam_pipe_reg #(.W(D_W)) dStage  (.clk(clk), .ce(ceD),  .rst(rstD), .d(dIn),   .q(dReg));

  // pre-adder
  logic [PRE_W-1:0] aLow, preSum, adReg;
  assign aLow   = aReg[PRE_W-1:0];
  assign preSum = strb.preSub ? (dReg - aLow) : (dReg + aLow);

  always_ff @(posedge clk) begin
    if (rstAd)     adReg <= '0;
    else if (ceAd) adReg <= preSum;
  end

  // multiplier
  logic [B_W-1:0]    bSel;
  logic signed [PROD_W-1:0] adWide, bWide, prodFull;
  logic [PROD_W-1:0] mReg;

  assign bSel     = strb.bFirst ? b1Reg : b2Reg;
  assign adWide   = $signed({{B_W{adReg[PRE_W-1]}}, adReg});
  assign bWide    = $signed({{PRE_W{bSel[B_W-1]}}, bSel});
  assign prodFull = adWide * bWide;

  always_ff @(posedge clk) begin
    if (rstM)     mReg <= '0;
    else if (ceM) mReg <= prodFull;
  end

  // post-adder operand selection
  logic [P_W-1:0] mExt, xVal, yVal, zVal, sumXY, pNext, pReg;
  assign mExt = {{EXT_W{mReg[PROD_W-1]}}, mReg};

  always_comb begin
    unique case (strb.xSel)
      XS_PROD: xVal = mExt;
      XS_P:    xVal = pReg;
      XS_AB:   xVal = P_W'({aReg, b2Reg});
      default: xVal = '0;
    endcase
    unique case (strb.ySel)
      YS_ONES: yVal = '1;
      YS_C:    yVal = P_W'(cReg);
      default: yVal = '0;
    endcase
    unique case (strb.zSel)
      ZS_P:    zVal = pReg;
      ZS_C:    zVal = P_W'(cReg);
      default: zVal = '0;
    endcase
  end

  assign sumXY = xVal + yVal + P_W'(strb.carry);
  assign pNext = strb.aluSub ? (zVal - sumXY) : (zVal + sumXY);

  always_ff @(posedge clk) begin
    if (rstP)     pReg <= '0;
    else if (ceP) pReg <= pNext;
  end

  assign pOut = pReg;

  // R1: output register clears, enable or not
  p_p_clear_r1: assert property (@(posedge clk) rstP |=> (pReg == '0));

  // R12: held output and product registers
  p_p_hold_r12: assert property (@(posedge clk) disable iff (rstP)
    !ceP |=> $stable(pReg));
  p_m_hold_r12: assert property (@(posedge clk) disable iff (rstM)
    !ceM |=> $stable(mReg));

  // R9: all-zero selection with no carry yields zero
  p_opzero_r9: assert property (@(posedge clk) disable iff (rstP)
    (ceP && strb.xSel == XS_ZERO && strb.ySel == YS_ZERO &&
     strb.zSel == ZS_ZERO && !strb.carry) |=> (pReg == '0));

  // R3/R7: product alone routed through the post-adder lands on P sign-extended
  p_prod_to_p_r3: assert property (@(posedge clk) disable iff (rstP)
    (ceP && strb.xSel == XS_PROD && strb.ySel == YS_ZERO &&
     strb.zSel == ZS_ZERO && !strb.aluSub && !strb.carry)
    |=> ($signed(pReg) == $signed($past(mReg))));

endmodule

// File: rtl/preadd_mac_slice.sv
module preadd_mac_slice
  import pam_pkg::*;
#(
  parameter int A_W = 30,
  parameter int B_W = 18,
  parameter int C_W = 48,
  parameter int D_W = 25,
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic [A_W-1:0] aIn,
  input  logic [B_W-1:0] bIn,
  input  logic [C_W-1:0] cIn,
  input  logic [D_W-1:0] dIn,
  input  logic [4:0]     inMode,
  input  logic [6:0]     opMode,
  input  logic [3:0]     aluMode,
  input  logic           carryIn,
  input  logic           ceA,
  input  logic           ceB1,
  input  logic           ceB2,
  input  logic           ceC,
  input  logic           ceD,
  input  logic           ceAd,
  input  logic           ceM,
  input  logic           ceP,
  input  logic           ceInMode,
  input  logic           ceCtrl,
  input  logic           rstA,
  input  logic           rstB,
  input  logic           rstC,
  input  logic           rstD,
  input  logic           rstAd,
  input  logic           rstM,
  input  logic           rstP,
  input  logic           rstInMode,
  input  logic           rstCtrl,
  output logic [P_W-1:0] pOut
);

  ctrlStrbT strb;

  pam_ctrl ctrlU (
    .clk(clk), .inMode(inMode), .opMode(opMode), .aluMode(aluMode),
    .carryIn(carryIn), .ceInMode(ceInMode), .ceCtrl(ceCtrl),
    .rstInMode(rstInMode), .rstCtrl(rstCtrl), .strb(strb)
  );

  pam_datapath #(
    .A_W(A_W), .B_W(B_W), .C_W(C_W), .D_W(D_W), .P_W(P_W)
  ) dpU (
    .clk(clk), .aIn(aIn), .bIn(bIn), .cIn(cIn), .dIn(dIn),
    .ceA(ceA), .ceB1(ceB1), .ceB2(ceB2), .ceC(ceC), .ceD(ceD),
    .ceAd(ceAd), .ceM(ceM), .ceP(ceP),
    .rstA(rstA), .rstB(rstB), .rstC(rstC), .rstD(rstD),
    .rstAd(rstAd), .rstM(rstM), .rstP(rstP),
    .strb(strb), .pOut(pOut)
  );

endmodule

// File: tb/preadd_mac_slice_tb_top.sv
module preadd_mac_slice_tb_top;

  logic        clk = 1'b0;
  logic [29:0] aIn;
  logic [17:0] bIn;
  logic [47:0] cIn;
  logic [24:0] dIn;
  logic [4:0]  inMode;
  logic [6:0]  opMode;
  logic [3:0]  aluMode;
  logic        carryIn;
  logic ceA, ceB1, ceB2, ceC, ceD, ceAd, ceM, ceP, ceInMode, ceCtrl;
  logic rstA, rstB, rstC, rstD, rstAd, rstM, rstP, rstInMode, rstCtrl;
  logic [47:0] pOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  preadd_mac_slice dut_i (
    .clk(clk), .aIn(aIn), .bIn(bIn), .cIn(cIn), .dIn(dIn),
    .inMode(inMode), .opMode(opMode), .aluMode(aluMode), .carryIn(carryIn),
    .ceA(ceA), .ceB1(ceB1), .ceB2(ceB2), .ceC(ceC), .ceD(ceD),
    .ceAd(ceAd), .ceM(ceM), .ceP(ceP), .ceInMode(ceInMode), .ceCtrl(ceCtrl),
    .rstA(rstA), .rstB(rstB), .rstC(rstC), .rstD(rstD), .rstAd(rstAd),
    .rstM(rstM), .rstP(rstP), .rstInMode(rstInMode), .rstCtrl(rstCtrl),
    .pOut(pOut)
  );

  localparam logic [4:0] IM_SUB   = 5'b01000;
  localparam logic [4:0] IM_ADD   = 5'b00000;
  localparam logic [4:0] IM_SUBB1 = 5'b11000;
  localparam logic [6:0] OP_MUL   = 7'b0000101;

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setAllRst(input logic v);
    {rstA, rstB, rstC, rstD, rstAd, rstM, rstP, rstInMode, rstCtrl} = {9{v}};
  endtask

  task automatic setAllCe(input logic v);
    {ceA, ceB1, ceB2, ceC, ceD, ceAd, ceM, ceP, ceInMode, ceCtrl} = {10{v}};
  endtask

  task automatic setup(input logic [29:0] a, input logic [17:0] b, input logic [24:0] d,
                       input logic [4:0] im, input logic [6:0] op);
    aIn = a; bIn = b; dIn = d; inMode = im; opMode = op;
  endtask

  // R1: reset state
  task automatic tReset;
    setAllRst(1'b1); setAllCe(1'b1);
    setup(30'd5, 18'd1, 25'd20, IM_SUB, OP_MUL);
    cIn = 48'd0; aluMode = 4'd0; carryIn = 1'b0;
    edges(3);
    check("R1 reset clears output", pOut, 48'd0);
    setAllRst(1'b0);
  endtask

  // R2/R4: subtract and latency
  task automatic tSubLatency;
    edges(6);
    check("R2 D-A times B = 15", pOut, 48'd15);
    dIn = 25'd30;
    edges(3);
    check("R4 old value before 4th edge", pOut, 48'd15);
    edges(1);
    check("R4 new value at 4th edge", pOut, 48'd25);
  endtask

  // R2/R3: add direction, negative product, upper A bits ignored
  task automatic tAddNeg;
    setup(30'd10, 18'd6, 25'd3, IM_ADD, OP_MUL);
    edges(6);
    check("R2 D+A times B = 78", pOut, 48'd78);
    inMode = IM_SUB;
    edges(6);
    check("R3 negative product -42", pOut, -48'sd42);
    aIn = 30'h2000000 | 30'd10;
    edges(6);
    check("R2 A[29:25] ignored", pOut, -48'sd42);
  endtask

  // R9/R11: zero opMode, control latency
  task automatic tOpZero;
    opMode = 7'b0;
    edges(1);
    check("R11 first edge uses old code", pOut, -48'sd42);
    edges(1);
    check("R9 opMode zero gives 0", pOut, 48'd0);
  endtask

  // R6: accumulate through Z = P
  task automatic tAccum;
    setup(30'd5, 18'd1, 25'd20, IM_SUB, OP_MUL);
    edges(6);
    opMode = 7'b0100101; rstP = 1'b1;
    edges(1);
    check("R1 output reset", pOut, 48'd0);
    rstP = 1'b0;
    edges(1);
    check("R6 accumulate step 1", pOut, 48'd15);
    edges(1);
    check("R6 accumulate step 2", pOut, 48'd30);
  endtask

  // R6/R10: C plus product, ALU codes, carry
  task automatic tCAndAlu;
    opMode = 7'b0110101; cIn = 48'd100;
    edges(3);
    check("R6 Z=C plus product", pOut, 48'd115);
    aluMode = 4'b0011;
    edges(3);
    check("R10 Z minus product", pOut, 48'd85);
    carryIn = 1'b1;
    edges(3);
    check("R10 Z minus product and carry", pOut, 48'd84);
    aluMode = 4'b0000;
    edges(3);
    check("R10 add with carry", pOut, 48'd116);
    aluMode = 4'b0101; carryIn = 1'b0;
    edges(3);
    check("R10 other code adds", pOut, 48'd115);
    aluMode = 4'b0000;
  endtask

  // R7/R8: selector corners
  task automatic tSelectors;
    opMode = 7'b0000001;
    edges(3);
    check("R7 X half alone gives 0", pOut, 48'd0);
    opMode = 7'b0000100;
    edges(3);
    check("R7 Y half alone gives 0", pOut, 48'd0);
    opMode = 7'b0001000;
    edges(3);
    check("R8 Y all ones", pOut, {48{1'b1}});
    opMode = 7'b0001100;
    edges(3);
    check("R8 Y = C", pOut, 48'd100);
    opMode = 7'b0000011;
    edges(3);
    check("R8 X = {A,B}", pOut, (48'd5 << 18) | 48'd1);
    opMode = 7'b0000010;
    edges(3);
    check("R8 X = P holds", pOut, (48'd5 << 18) | 48'd1);
  endtask

  // R5: first B stage shortens B path
  task automatic tBFirst;
    setup(30'd5, 18'd1, 25'd20, IM_SUBB1, OP_MUL);
    edges(6);
    check("R5 steady with first B stage", pOut, 48'd15);
    bIn = 18'd2;
    edges(2);
    check("R5 old before 3rd edge", pOut, 48'd15);
    edges(1);
    check("R5 new at 3rd edge", pOut, 48'd30);
  endtask

  // R12/R1: enables hold, reset beats enable
  task automatic tHold;
    ceP = 1'b0; opMode = 7'b0;
    edges(4);
    check("R12 ceP low holds", pOut, 48'd30);
    rstP = 1'b1;
    edges(1);
    check("R1 reset wins over low enable", pOut, 48'd0);
    rstP = 1'b0; opMode = OP_MUL;
    edges(3);
    check("R12 stays cleared while disabled", pOut, 48'd0);
    ceP = 1'b1;
    edges(3);
    check("R12 resumes when enabled", pOut, 48'd30);
    ceM = 1'b0; bIn = 18'd3;
    edges(6);
    check("R12 ceM low blocks B change", pOut, 48'd30);
    ceM = 1'b1;
    edges(3);
    check("R12 ceM high passes B change", pOut, 48'd45);
  endtask

  initial begin
    tReset();
    tSubLatency();
    tAddNeg();
    tOpZero();
    tAccum();
    tCAndAlu();
    tSelectors();
    tBFirst();
    tHold();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule